// File: doc/BRIEF.md
# Chained Descriptor Transfer Controller

This block moves single data words between memory locations on behalf of a set of event sources, without CPU involvement. Each source owns an entry in a vector table at the bottom of a shared memory. The entry names a control record held in a record area. When an enabled source raises a request, the engine looks up the source's vector and loads the record it names. It then copies one word from the record's source pointer to its destination pointer. Finally it writes the updated count and pointers back into the record. If the record's chain flag is set, the engine continues with the record stored directly after it, without waiting for a new request, until a record with a clear chain flag has been handled.

Each record counts in one of two modes. In normal mode the count simply decrements. In repeat mode a count that runs out is reloaded from a stored size, and both pointers return to their stored start values. When the first record of an activation runs its count out, the engine pulses an interrupt line for that source and clears the source's enable bit. Normal mode always interrupts in that case; repeat mode does so only when the record's interrupt bit allows it. A parameter mask names sources that never interrupt. Requests that arrive while the engine is busy are held pending and served lowest index first.

Memory layout: the vector entry for source `s` is at word address `s`, and its low 5 bits give a record index. Record `k` occupies the four words starting at `REC_BASE + 4*k`:
- word 0 is control: bit 31 repeat mode, bit 30 chain, bit 29 repeat-interrupt enable, bit 28 source increment, bit 27 destination increment, bits 15:8 reload size, bits 7:0 count.
- word 1 is the source pointer.
- word 2 is the destination pointer.
- word 3 holds the start values, with the source start in bits 31:16 and the destination start in bits 15:0.

Top module: `chain_xfer_ctrl`

## Requirements
- R1: A request on an enabled source causes the word at that source's record's source pointer to be written to the record's destination pointer. The updated control word and both pointers are then written back to record words 0, 1 and 2.
- R2: In normal mode the count field (control bits 7:0) is written back one lower. Each pointer is written back one higher when its increment bit (28 for source, 27 for destination) is 1, and unchanged otherwise.
- R3: When a processed record has chain bit 30 set, the record with the next index is processed without a new request. Processing stops after the first record whose chain bit is 0, and no later record is read or changed.
- R4: Record index 23 always ends a chain, even when its chain bit is set.
- R5: When the first record of an activation is in normal mode and its count goes from 1 to 0, `irqOut` pulses high for one cycle on that source's bit only, and that source's bit in `srcEn` reads 0 from then on.
- R6: In repeat mode (bit 31 = 1), a count going from 1 to 0 is written back as the reload size (bits 15:8). The source and destination pointers are written back as the start values in word 3. An interrupt, with the enable cleared, happens only when bit 29 is 1.
- R7: In a chain, the interrupt and enable clearing depend only on the first record: a later record reaching 0 raises nothing.
- R8: A source set in `NO_IRQ_MASK` (default: source 12) never raises `irqOut` and keeps its enable, even when its count reaches 0.
- R9: Requests arriving while an activation is in progress are held and all served afterwards, lower source index first.
- R10: A request on a source whose `srcEn` bit is 0 is ignored and performs no transfer.
- R11: After reset all `srcEn` bits are 0, `irqOut` is 0 and `memReq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | NUM_SRC | One-cycle activation requests, one bit per source |
| enSet | input | NUM_SRC | One-cycle pulses that set source enable bits |
| srcEn | output | NUM_SRC | Current source enable bits |
| irqOut | output | NUM_SRC | One-cycle interrupt pulse per source |
| memReq | output | 1 | Memory access strobe |
| memWe | output | 1 | Write when high, read when low |
| memAddr | output | ADDR_W | Word address |
| memWdata | output | DATA_W | Write data |
| memRdata | input | DATA_W | Read data, valid the cycle after a read strobe |

## Verification
The assertions assume that record areas and all source and destination pointers lie above the vector table, so any access below `NUM_SRC` is a vector read. They also assume that the memory returns read data one cycle after the strobe, and that `enSet` never pulses a source in the same cycle that source interrupts. The bench places records from address 32 and data from address 160, answers reads with a one-cycle registered model, and sets enables only while the engine is idle.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_VEC, S_VECW, S_RREC, S_RRECW, S_XRD, S_XRDW, S_XWR, S_WB, S_FIN
  } seqState_e;

  typedef enum logic [1:0] {A_VEC, A_REC, A_SRC, A_DST} addrSel_e;

  typedef struct packed {
    logic     rdEn;
    logic     wrEn;
    addrSel_e addrSel;
    logic [1:0] word;
    logic     capVec;
    logic     capRec;
    logic     capData;
    logic     nextRec;
  } dpStrobe_t;

endpackage

// File: rtl/xfer_datapath.sv
module xfer_datapath
  import xfer_pkg::*;
#(
  parameter int NUM_SRC  = 24,
  parameter int NUM_REC  = 24,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int REC_BASE = 32,
  localparam int SRC_W   = $clog2(NUM_SRC),
  localparam int REC_W   = $clog2(NUM_REC + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [SRC_W-1:0]  srcIdx,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              chainFlag,
  output logic              lastRec,
  output logic              irqHit
);

  logic [REC_W-1:0]  recIdx;
  logic [DATA_W-1:0] ctrlW, initW, dataR;
  logic [ADDR_W-1:0] srcPtr, dstPtr;

  logic       modeRpt, rptIe, srcInc, dstInc, reachZero;
  logic [7:0] cnt, reload, newCnt;
  logic [ADDR_W-1:0] newSrc, newDst, recAddr;
  logic [DATA_W-1:0] newCtrl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      recIdx <= '0;
      ctrlW  <= '0;
      initW  <= '0;
      dataR  <= '0;
      srcPtr <= '0;
      dstPtr <= '0;
    end else begin
      if (stb.capVec)  recIdx <= memRdata[REC_W-1:0];
      if (stb.nextRec) recIdx <= recIdx + 1'b1;
      if (stb.capData) dataR  <= memRdata;
      if (stb.capRec) begin
        case (stb.word)
          2'd0:    ctrlW  <= memRdata;
          2'd1:    srcPtr <= memRdata[ADDR_W-1:0];
          2'd2:    dstPtr <= memRdata[ADDR_W-1:0];
          default: initW  <= memRdata;
        endcase
      end
    end
  end

  // record field decode
  assign modeRpt   = ctrlW[31];
  assign chainFlag = ctrlW[30];
  assign rptIe     = ctrlW[29];
  assign srcInc    = ctrlW[28];
  assign dstInc    = ctrlW[27];
  assign reload    = ctrlW[15:8];
  assign cnt       = ctrlW[7:0];
  assign reachZero = (cnt == 8'd1);
  assign irqHit    = reachZero && (!modeRpt || rptIe);
  assign lastRec   = (recIdx == REC_W'(NUM_REC - 1));

  // write-back values
  always_comb begin
    if (reachZero && modeRpt) begin
      newCnt = reload;
      newSrc = initW[31:16];
      newDst = initW[15:0];
    end else begin
      newCnt = cnt - 8'd1;
      newSrc = srcPtr + ADDR_W'(srcInc);
      newDst = dstPtr + ADDR_W'(dstInc);
    end
    newCtrl = {ctrlW[DATA_W-1:8], newCnt};
  end

  assign recAddr = ADDR_W'(REC_BASE) + ADDR_W'({recIdx, stb.word});

  always_comb begin
    memReq = stb.rdEn | stb.wrEn;
    memWe  = stb.wrEn;
    case (stb.addrSel)
      A_VEC:   memAddr = ADDR_W'(srcIdx);
      A_REC:   memAddr = recAddr;
      A_SRC:   memAddr = srcPtr;
      default: memAddr = dstPtr;
    endcase
    if (stb.addrSel == A_DST) memWdata = dataR;
    else begin
      case (stb.word)
        2'd0:    memWdata = newCtrl;
        2'd1:    memWdata = DATA_W'(newSrc);
        default: memWdata = DATA_W'(newDst);
      endcase
    end
  end

endmodule

// File: rtl/xfer_sequencer.sv
module xfer_sequencer
  import xfer_pkg::*;
#(
  parameter int NUM_SRC = 24,
  parameter logic [NUM_SRC-1:0] NO_IRQ_MASK = 24'h00_1000,
  localparam int SRC_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic [NUM_SRC-1:0] enSet,
  input  logic               chainFlag,
  input  logic               lastRec,
  input  logic               irqHit,
  output logic [NUM_SRC-1:0] srcEn,
  output logic [NUM_SRC-1:0] irqOut,
  output logic [SRC_W-1:0]   srcIdx,
  output dpStrobe_t          stb
);

  seqState_e state, stateNext;
  logic [1:0] word, wordNext;
  logic [NUM_SRC-1:0] pend, en, clrPend, clrEn, irqNext;
  logic [SRC_W-1:0] srcNext, pickIdx;
  logic first, firstNext;

  // lowest pending index wins
  always_comb begin
    pickIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (pend[i]) pickIdx = SRC_W'(i);
  end

  always_comb begin
    stateNext = state;
    wordNext  = word;
    srcNext   = srcIdx;
    firstNext = first;
    clrPend   = '0;
    clrEn     = '0;
    irqNext   = '0;
    stb       = '0;
    stb.word  = word;
    case (state)
      S_IDLE: if (|pend) begin
        srcNext   = pickIdx;
        clrPend   = NUM_SRC'(1) << pickIdx;
        firstNext = 1'b1;
        stateNext = S_VEC;
      end
      S_VEC: begin
        stb.rdEn = 1'b1; stb.addrSel = A_VEC; stateNext = S_VECW;
      end
      S_VECW: begin
        stb.capVec = 1'b1; wordNext = '0; stateNext = S_RREC;
      end
      S_RREC: begin
        stb.rdEn = 1'b1; stb.addrSel = A_REC; stateNext = S_RRECW;
      end
      S_RRECW: begin
        stb.capRec = 1'b1;
        if (word == 2'd3) stateNext = S_XRD;
        else begin wordNext = word + 2'd1; stateNext = S_RREC; end
      end
      S_XRD: begin
        stb.rdEn = 1'b1; stb.addrSel = A_SRC; stateNext = S_XRDW;
      end
      S_XRDW: begin
        stb.capData = 1'b1; stateNext = S_XWR;
      end
      S_XWR: begin
        stb.wrEn = 1'b1; stb.addrSel = A_DST; wordNext = '0; stateNext = S_WB;
      end
      S_WB: begin
        stb.wrEn = 1'b1; stb.addrSel = A_REC;
        if (word == 2'd2) stateNext = S_FIN;
        else wordNext = word + 2'd1;
      end
      S_FIN: begin
        if (first && irqHit && !NO_IRQ_MASK[srcIdx]) begin
          irqNext = NUM_SRC'(1) << srcIdx;
          clrEn   = NUM_SRC'(1) << srcIdx;
        end
        firstNext = 1'b0;
        if (chainFlag && !lastRec) begin
          stb.nextRec = 1'b1; wordNext = '0; stateNext = S_RREC;
        end else stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      word   <= '0;
      srcIdx <= '0;
      first  <= 1'b0;
      pend   <= '0;
      en     <= '0;
      irqOut <= '0;
    end else begin
      state  <= stateNext;
      word   <= wordNext;
      srcIdx <= srcNext;
      first  <= firstNext;
      pend   <= (pend & ~clrPend) | (reqIn & en);
      en     <= (en & ~clrEn) | enSet;
      irqOut <= irqNext;
    end
  end

  assign srcEn = en;

endmodule

// File: rtl/chain_xfer_ctrl.sv
module chain_xfer_ctrl
  import xfer_pkg::*;
#(
  parameter int NUM_SRC  = 24,
  parameter int NUM_REC  = 24,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int REC_BASE = 32,
  parameter logic [NUM_SRC-1:0] NO_IRQ_MASK = 24'h00_1000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic [NUM_SRC-1:0] enSet,
  output logic [NUM_SRC-1:0] srcEn,
  output logic [NUM_SRC-1:0] irqOut,
  output logic               memReq,
  output logic               memWe,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [DATA_W-1:0]  memWdata,
  input  logic [DATA_W-1:0]  memRdata
);

  localparam int SRC_W = $clog2(NUM_SRC);

  dpStrobe_t stb;
  logic [SRC_W-1:0] srcIdx;
  logic chainFlag, lastRec, irqHit;

  xfer_sequencer #(.NUM_SRC(NUM_SRC), .NO_IRQ_MASK(NO_IRQ_MASK)) u_seq (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .enSet(enSet),
    .chainFlag(chainFlag), .lastRec(lastRec), .irqHit(irqHit),
    .srcEn(srcEn), .irqOut(irqOut), .srcIdx(srcIdx), .stb(stb)
  );

  xfer_datapath #(.NUM_SRC(NUM_SRC), .NUM_REC(NUM_REC), .ADDR_W(ADDR_W),
                  .DATA_W(DATA_W), .REC_BASE(REC_BASE)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .srcIdx(srcIdx), .memRdata(memRdata),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .chainFlag(chainFlag), .lastRec(lastRec), .irqHit(irqHit)
  );

endmodule

// File: rtl/chain_xfer_ctrl_chk.sv
module chain_xfer_ctrl_chk #(
  parameter int NUM_SRC = 24,
  parameter int ADDR_W  = 16,
  parameter logic [NUM_SRC-1:0] NO_IRQ_MASK = 24'h00_1000
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcEn,
  input logic [NUM_SRC-1:0] irqOut,
  input logic               memReq,
  input logic               memWe,
  input logic [ADDR_W-1:0]  memAddr
);

  // R5
  irq_single_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqOut));

  // R5
  irq_drops_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|irqOut) |-> ((srcEn & irqOut) == '0));

  // R8
  masked_no_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut & NO_IRQ_MASK) == '0);

  // R1
  vector_read_after_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe && (memAddr < ADDR_W'(NUM_SRC))) |-> $past(!memReq));

  // R1
  no_vector_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> (memAddr >= ADDR_W'(NUM_SRC)));

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rstN) |-> (!memReq && irqOut == '0 && srcEn == '0));

endmodule

bind chain_xfer_ctrl chain_xfer_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .NO_IRQ_MASK(NO_IRQ_MASK)
) u_chk (
  .clk(clk), .rstN(rstN), .srcEn(srcEn), .irqOut(irqOut),
  .memReq(memReq), .memWe(memWe), .memAddr(memAddr)
);

// File: tb/chain_xfer_ctrl_bench.sv
module chain_xfer_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NS-1:0] reqIn = '0, enSet = '0, srcEn, irqOut;
  logic memReq, memWe;
  logic [15:0] memAddr;
  logic [31:0] memWdata, memRdata;
  logic [31:0] mem [0:255];
  int irqCnt [NS];
  int nChecks = 0, nFail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chain_xfer_ctrl u_chain_xfer_ctrl (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .enSet(enSet), .srcEn(srcEn),
    .irqOut(irqOut), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  always @(posedge clk) begin
    if (memReq) begin
      if (memWe) mem[memAddr[7:0]] <= memWdata;
      else memRdata <= mem[memAddr[7:0]];
    end
    for (int i = 0; i < NS; i++) if (irqOut[i]) irqCnt[i] = irqCnt[i] + 1;
  end

  function automatic logic [31:0] mkCtrl(bit rpt, bit chn, bit ie, bit si, bit di,
                                         logic [7:0] size, logic [7:0] cnt);
    return {rpt, chn, ie, si, di, 11'b0, size, cnt};
  endfunction

  function automatic int recA(int k);
    return 32 + 4 * k;
  endfunction

  task automatic checkEq(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setRec(int k, logic [31:0] c, int s, int d, logic [31:0] ini);
    mem[recA(k)] = c; mem[recA(k)+1] = 32'(s); mem[recA(k)+2] = 32'(d);
    mem[recA(k)+3] = ini;
  endtask

  task automatic enable(int s);
    @(negedge clk) enSet = NS'(1) << s;
    @(negedge clk) enSet = '0;
  endtask

  task automatic request(int s);
    @(negedge clk) reqIn = NS'(1) << s;
    @(negedge clk) reqIn = '0;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    checkEq("R11 srcEn", srcEn, 0);
    checkEq("R11 irqOut", irqOut, 0);
    checkEq("R11 memReq", memReq, 0);
    mem[0] = 0; setRec(0, mkCtrl(0,0,0,0,0,0,9), 184, 224, 0);
    mem[184] = 32'hCC; mem[224] = 0;
    request(0); settle(40);
    checkEq("R10 disabled source no transfer", mem[224], 0);
    checkEq("R10 disabled source record", mem[recA(0)][7:0], 9);
  endtask

  task automatic t_normal;
    mem[1] = 3; setRec(3, mkCtrl(0,0,0,1,1,0,5), 160, 200, 0);
    mem[160] = 32'hA5; mem[161] = 32'h5A; mem[200] = 0;
    enable(1); request(1); settle(40);
    checkEq("R1 data moved", mem[200], 32'hA5);
    checkEq("R2 count", mem[recA(3)][7:0], 4);
    checkEq("R2 src ptr", mem[recA(3)+1], 161);
    checkEq("R2 dst ptr", mem[recA(3)+2], 201);
    checkEq("R5 no irq above 1", irqCnt[1], 0);
    request(1); settle(40);
    checkEq("R2 second move uses new ptrs", mem[201], 32'h5A);
  endtask

  task automatic t_normalIrq;
    mem[4] = 4; setRec(4, mkCtrl(0,0,0,0,0,0,1), 164, 204, 0);
    mem[164] = 32'h11; mem[204] = 0;
    enable(4); request(4); settle(40);
    checkEq("R5 irq pulse", irqCnt[4], 1);
    checkEq("R5 enable cleared", srcEn[4], 0);
    checkEq("R2 count to 0", mem[recA(4)][7:0], 0);
    checkEq("R2 fixed ptr", mem[recA(4)+1], 164);
    mem[164] = 32'h22; request(4); settle(40);
    checkEq("R10 request after disable ignored", mem[204], 32'h11);
  endtask

  task automatic t_repeat;
    mem[6] = 6; setRec(6, mkCtrl(1,0,0,1,1,3,1), 170, 210, {16'd168, 16'd208});
    mem[170] = 32'h33; mem[210] = 0;
    enable(6); request(6); settle(40);
    checkEq("R6 data moved", mem[210], 32'h33);
    checkEq("R6 reload", mem[recA(6)][7:0], 3);
    checkEq("R6 src restored", mem[recA(6)+1], 168);
    checkEq("R6 dst restored", mem[recA(6)+2], 208);
    checkEq("R6 no irq without bit 29", irqCnt[6], 0);
    checkEq("R6 enable kept", srcEn[6], 1);
    mem[7] = 7; setRec(7, mkCtrl(1,0,1,0,0,3,1), 172, 212, {16'd172, 16'd212});
    enable(7); request(7); settle(40);
    checkEq("R6 irq with bit 29", irqCnt[7], 1);
    checkEq("R6 enable cleared", srcEn[7], 0);
    checkEq("R6 reload with irq", mem[recA(7)][7:0], 3);
  endtask

  task automatic t_chain;
    mem[8] = 10;
    setRec(10, mkCtrl(0,1,0,0,0,0,5), 174, 214, 0);
    setRec(11, mkCtrl(0,1,0,0,0,0,1), 175, 215, 0);
    setRec(12, mkCtrl(0,0,0,0,0,0,1), 176, 216, 0);
    setRec(13, mkCtrl(0,0,0,0,0,0,9), 177, 217, 0);
    mem[174] = 32'h44; mem[175] = 32'h55; mem[176] = 32'h66; mem[177] = 32'h77;
    mem[217] = 0;
    enable(8); request(8); settle(80);
    checkEq("R3 first record", mem[214], 32'h44);
    checkEq("R3 second record", mem[215], 32'h55);
    checkEq("R3 third record", mem[216], 32'h66);
    checkEq("R3 stops at clear chain bit", mem[217], 0);
    checkEq("R3 record after end untouched", mem[recA(13)][7:0], 9);
    checkEq("R7 later record no irq", irqCnt[8], 0);
    checkEq("R7 enable kept", srcEn[8], 1);
    mem[recA(10)] = mkCtrl(0,1,0,0,0,0,1);
    mem[recA(11)] = mkCtrl(0,1,0,0,0,0,5);
    request(8); settle(80);
    checkEq("R7 first record irq", irqCnt[8], 1);
    checkEq("R7 enable cleared", srcEn[8], 0);
  endtask

  task automatic t_last;
    mem[9] = 23;
    setRec(23, mkCtrl(0,1,0,0,0,0,5), 178, 218, 0);
    setRec(24, mkCtrl(0,0,0,0,0,0,5), 179, 219, 0);
    mem[178] = 32'h88; mem[179] = 32'h99; mem[219] = 0;
    enable(9); request(9); settle(80);
    checkEq("R4 slot 23 moved", mem[218], 32'h88);
    checkEq("R4 no record past 23", mem[219], 0);
    checkEq("R4 record past 23 count", mem[recA(24)][7:0], 5);
  endtask

  task automatic t_mask;
    mem[12] = 14; setRec(14, mkCtrl(0,0,0,0,0,0,1), 180, 220, 0);
    mem[180] = 32'hAA;
    enable(12); request(12); settle(40);
    checkEq("R8 data moved", mem[220], 32'hAA);
    checkEq("R8 count 0", mem[recA(14)][7:0], 0);
    checkEq("R8 no irq", irqCnt[12], 0);
    checkEq("R8 enable kept", srcEn[12], 1);
  endtask

  task automatic t_queue;
    mem[7] = 16; mem[2] = 17; mem[5] = 18;
    setRec(16, mkCtrl(0,0,0,0,0,0,9), 181, 221, 0);
    setRec(17, mkCtrl(0,0,0,0,0,0,9), 182, 223, 0);
    setRec(18, mkCtrl(0,0,0,0,0,0,9), 183, 223, 0);
    mem[181] = 32'h01; mem[182] = 32'h02; mem[183] = 32'h05;
    enable(7); enable(2); enable(5);
    request(7);
    @(negedge clk) reqIn = (NS'(1) << 2) | (NS'(1) << 5);
    @(negedge clk) reqIn = '0;
    settle(120);
    checkEq("R9 busy source served", mem[221], 32'h01);
    checkEq("R9 lower index first", mem[223], 32'h05);
    checkEq("R9 source 2 served", mem[recA(17)][7:0], 8);
    checkEq("R9 source 5 served", mem[recA(18)][7:0], 8);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 0;
    for (int i = 0; i < NS; i++) irqCnt[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset;
    t_normal;
    t_normalIrq;
    t_repeat;
    t_chain;
    t_last;
    t_mask;
    t_queue;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

endmodule